// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block carries out every stack movement of a small 8-bit processor: pushing and pulling a register byte, the return-address save and branch of a subroutine call, the return that restores the program counter, and the entry into an interrupt handler. It holds an 8-bit stack pointer and a 3-bit step counter. It forms each stack address from a software-written page byte (high half) and the pointer (low half), so the stack spans one 256-byte page. In every step it drives read and write strobes, the address and the write byte, and it tells the program counter when to load its high or low half and with what value.

The instruction decoder hands the block a command after the two fetch cycles of an instruction, so command steps are numbered from 2. An interrupt is taken in place of a fetch: when the processor signals the start of a fetch, an interrupt is pending, the mask is clear and the block is idle, the block pushes the program counter and status, then loads the handler address from two software-written vector bytes. Taking an interrupt sets the mask, and only a software write clears it. A small register window gives software access to the page byte, the two vector bytes and the mask.

The RAM answers reads in the same cycle (asynchronous read data), so each step moves exactly one byte.

Top module: `stk_seq`

## Requirements
- R1: After reset the stack pointer is 0xFF, the block is idle (busy low, step 0), no strobe or program-counter load is active, the mask reads 1, the page byte reads 0x01 and both vector bytes read 0x00.
- R2: A push (cmd_op 0) takes one busy cycle at step 2: it writes push_data to {page, SP} and then SP decreases by one.
- R3: A pull (cmd_op 1) takes one busy cycle at step 2: SP increases by one and the byte at {page, SP+1} is read and presented on pull_data with pull_valid high.
- R4: A call (cmd_op 2) takes three busy cycles: step 2 writes pc_in[15:8] to {page, SP}, step 3 writes pc_in[7:0] to {page, SP-1}, step 4 loads both program-counter halves from call_target. SP ends two lower, so the return low byte sits at SP+1 and the high byte at SP+2.
- R5: A return (cmd_op 3) takes two busy cycles: step 2 reads {page, SP+1} into the program-counter low half, step 3 reads the next byte into the high half; SP ends two higher.
- R6: An interrupt is taken (irq_take high) only when irq_pend is high, the mask is 0, fetch_start is high and the block is idle; otherwise irq_pend has no effect.
- R7: Interrupt entry runs steps 0 to 4: write pc_in[15:8], write pc_in[7:0], write status_in (each at the current SP, SP then decreasing), load the vector high byte into the program-counter high half, then the vector low byte into the low half.
- R8: Taking an interrupt sets the mask; it stays set, blocking further interrupts, until software writes 0 to it.
- R9: The register window maps address 0 to the page byte, 1 to the vector high byte, 2 to the vector low byte and 3 to the mask (bit 0); reads return the value combinationally and the page byte written is used as the high address of every later stack access.
- R10: A command offered while busy, or in the same cycle an interrupt is taken, is dropped.
- R11: The stack pointer wraps inside its page: a pull from 0xFF reads address low byte 0x00, a push at 0x00 leaves SP at 0xFF.
- R12: Read and write strobes are never high together, and while idle no strobe and no program-counter load is active; every write uses low address SP and every read uses SP+1.
- R13: The step output starts at 2 for commands and 0 for interrupt entry and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register window write enable |
| cfg_addr | input | 2 | Register window address |
| cfg_wdata | input | 8 | Register window write data |
| cfg_rdata | output | 8 | Register window read data |
| fetch_start | input | 1 | Processor is at the start of an instruction fetch |
| irq_pend | input | 1 | Interrupt request pending |
| cmd_valid | input | 1 | Stack command offered |
| cmd_op | input | 2 | Command: 0 push, 1 pull, 2 call, 3 return |
| push_data | input | 8 | Byte to push |
| pc_in | input | 16 | Return address for a call, interrupted address for interrupt entry |
| status_in | input | 8 | Status byte saved on interrupt entry |
| call_target | input | 16 | Branch target of a call |
| mem_rdata | input | 8 | RAM read data (same cycle) |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |
| mem_addr | output | 16 | RAM address {page, pointer} |
| mem_wdata | output | 8 | RAM write data |
| pc_ld_hi | output | 1 | Load program-counter high half |
| pc_ld_lo | output | 1 | Load program-counter low half |
| pc_hi_val | output | 8 | Value for the high half |
| pc_lo_val | output | 8 | Value for the low half |
| pull_valid | output | 1 | Pulled byte is on pull_data |
| pull_data | output | 8 | Pulled byte |
| irq_take | output | 1 | Interrupt accepted this cycle |
| busy | output | 1 | A sequence is running |
| step | output | 3 | Current step number |
| sp_out | output | 8 | Stack pointer |

## Verification
The bench interleaves pushes and pulls so that last-in-first-out order shows up at pull_data; a design that pre-decremented on push or post-incremented on pull would return the wrong byte or be off by one address. It walks the pointer across the page edge in both directions, where a carry into the page byte would move the stack out of its page. It places a call and a return back to back and checks the byte order left at SP+1 and SP+2, which a swapped push order would reverse. For interrupts it tries a masked request, a request outside a fetch start and a command offered in the same cycle as a taken interrupt, and checks the five-step entry order and that the mask closes afterwards; a design that let the command through or missed the mask would show a wrong pointer or a second entry.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_PULL,
    SQ_CALL,
    SQ_RET,
    SQ_IRQ
  } seq_e;

  localparam int STEP_W = 3;

  localparam logic [1:0] OP_PUSH = 2'd0;
  localparam logic [1:0] OP_PULL = 2'd1;
  localparam logic [1:0] OP_CALL = 2'd2;
  localparam logic [1:0] OP_RET  = 2'd3;

  localparam logic [1:0] WIN_PAGE = 2'd0;
  localparam logic [1:0] WIN_VHI  = 2'd1;
  localparam logic [1:0] WIN_VLO  = 2'd2;
  localparam logic [1:0] WIN_MASK = 2'd3;

  localparam logic [STEP_W-1:0] CMD_FIRST = 3'd2;
  localparam logic [STEP_W-1:0] IRQ_FIRST = 3'd0;
  localparam logic [STEP_W-1:0] STEP_MAX  = 3'd4;

  function automatic seq_e op_to_seq(input logic [1:0] op);
    case (op)
      OP_PUSH: return SQ_PUSH;
      OP_PULL: return SQ_PULL;
      OP_CALL: return SQ_CALL;
      default: return SQ_RET;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] final_step(input seq_e s);
    case (s)
      SQ_CALL: return 3'd4;
      SQ_RET:  return 3'd3;
      SQ_IRQ:  return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/stk_cfg_regs.sv
module stk_cfg_regs
  import stk_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] PAGE_RST = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          mask_set,
  output logic [DW-1:0] page,
  output logic [DW-1:0] vec_hi,
  output logic [DW-1:0] vec_lo,
  output logic          mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page   <= PAGE_RST;
      vec_hi <= '0;
      vec_lo <= '0;
      mask   <= 1'b1;
    end else begin
      if (we && addr == WIN_PAGE) page   <= wdata;
      if (we && addr == WIN_VHI)  vec_hi <= wdata;
      if (we && addr == WIN_VLO)  vec_lo <= wdata;
      // hardware entry wins over a same-cycle software write
      if (mask_set)                    mask <= 1'b1;
      else if (we && addr == WIN_MASK) mask <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      WIN_PAGE: rdata = page;
      WIN_VHI:  rdata = vec_hi;
      WIN_VLO:  rdata = vec_lo;
      default:  rdata = {{(DW-1){1'b0}}, mask};
    endcase
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] SP_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] sp_plus
);

  // the pointer moves inside its page: arithmetic wraps at DW bits
  function automatic logic [DW-1:0] sp_move(input logic [DW-1:0] cur,
                                            input logic up, input logic down);
    if (up)   return cur + 1'b1;
    if (down) return cur - 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= SP_RST;
    else        sp <= sp_move(sp, inc, dec);
  end

  assign sp_plus = sp_move(sp, 1'b1, 1'b0);

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              irq_pend,
  input  logic              mask,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DW-1:0]     push_data,
  input  logic [AW-1:0]     pc_in,
  input  logic [DW-1:0]     status_in,
  input  logic [AW-1:0]     call_target,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [DW-1:0]     vec_hi,
  input  logic [DW-1:0]     vec_lo,
  output logic              rd,
  output logic              wr,
  output logic              inc,
  output logic              dec,
  output logic [DW-1:0]     wdata,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic [DW-1:0]     hi_val,
  output logic [DW-1:0]     lo_val,
  output logic              pull_v,
  output logic              irq_take,
  output logic              busy,
  output logic [STEP_W-1:0] step
);

  seq_e              seq_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]     lat_pc;
  logic [AW-1:0]     lat_tgt;
  logic [DW-1:0]     lat_d;
  logic              idle;
  logic              cmd_acc;

  assign idle     = (seq_q == SQ_IDLE);
  assign irq_take = idle && fetch_start && irq_pend && !mask;
  assign cmd_acc  = idle && cmd_valid && !irq_take;
  assign busy     = !idle;
  assign step     = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      step_q  <= '0;
      lat_pc  <= '0;
      lat_tgt <= '0;
      lat_d   <= '0;
    end else if (irq_take) begin
      seq_q  <= SQ_IRQ;
      step_q <= IRQ_FIRST;
      lat_pc <= pc_in;
      lat_d  <= status_in;
    end else if (cmd_acc) begin
      seq_q   <= op_to_seq(cmd_op);
      step_q  <= CMD_FIRST;
      lat_pc  <= pc_in;
      lat_tgt <= call_target;
      lat_d   <= push_data;
    end else if (!idle) begin
      if (step_q == final_step(seq_q)) begin
        seq_q  <= SQ_IDLE;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_comb begin
    rd     = 1'b0;
    wr     = 1'b0;
    inc    = 1'b0;
    dec    = 1'b0;
    wdata  = '0;
    ld_hi  = 1'b0;
    ld_lo  = 1'b0;
    hi_val = '0;
    lo_val = '0;
    pull_v = 1'b0;
    case (seq_q)
      SQ_PUSH: begin
        wr = 1'b1; dec = 1'b1; wdata = lat_d;
      end
      SQ_PULL: begin
        rd = 1'b1; inc = 1'b1; pull_v = 1'b1;
      end
      SQ_CALL: begin
        case (step_q)
          3'd2: begin wr = 1'b1; dec = 1'b1; wdata = lat_pc[AW-1:DW]; end
          3'd3: begin wr = 1'b1; dec = 1'b1; wdata = lat_pc[DW-1:0]; end
          default: begin
            ld_hi = 1'b1; ld_lo = 1'b1;
            hi_val = lat_tgt[AW-1:DW]; lo_val = lat_tgt[DW-1:0];
          end
        endcase
      end
      SQ_RET: begin
        rd = 1'b1; inc = 1'b1;
        if (step_q == CMD_FIRST) begin ld_lo = 1'b1; lo_val = mem_rdata; end
        else                     begin ld_hi = 1'b1; hi_val = mem_rdata; end
      end
      SQ_IRQ: begin
        case (step_q)
          3'd0: begin wr = 1'b1; dec = 1'b1; wdata = lat_pc[AW-1:DW]; end
          3'd1: begin wr = 1'b1; dec = 1'b1; wdata = lat_pc[DW-1:0]; end
          3'd2: begin wr = 1'b1; dec = 1'b1; wdata = lat_d; end
          3'd3: begin ld_hi = 1'b1; hi_val = vec_hi; end
          default: begin ld_lo = 1'b1; lo_val = vec_lo; end
        endcase
      end
      default: ;
    endcase
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step_q <= STEP_MAX);  // R13

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> step_q == CMD_FIRST);  // R13

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] SP_RST   = '1,
  parameter logic [DW-1:0] PAGE_RST = 8'h01,
  localparam int           AW       = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              fetch_start,
  input  logic              irq_pend,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DW-1:0]     push_data,
  input  logic [AW-1:0]     pc_in,
  input  logic [DW-1:0]     status_in,
  input  logic [AW-1:0]     call_target,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              pc_ld_hi,
  output logic              pc_ld_lo,
  output logic [DW-1:0]     pc_hi_val,
  output logic [DW-1:0]     pc_lo_val,
  output logic              pull_valid,
  output logic [DW-1:0]     pull_data,
  output logic              irq_take,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic [DW-1:0]     sp_out
);

  logic [DW-1:0] page_w, vhi_w, vlo_w, sp_plus_w;
  logic          mask_w, inc_w, dec_w;

  stk_cfg_regs #(.DW(DW), .PAGE_RST(PAGE_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .mask_set(irq_take),
    .page(page_w), .vec_hi(vhi_w), .vec_lo(vlo_w), .mask(mask_w)
  );

  stk_ptr #(.DW(DW), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(inc_w), .dec(dec_w),
    .sp(sp_out), .sp_plus(sp_plus_w)
  );

  stk_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .irq_pend(irq_pend),
    .mask(mask_w), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .pc_in(pc_in), .status_in(status_in),
    .call_target(call_target), .mem_rdata(mem_rdata),
    .vec_hi(vhi_w), .vec_lo(vlo_w), .rd(mem_rd), .wr(mem_wr),
    .inc(inc_w), .dec(dec_w), .wdata(mem_wdata),
    .ld_hi(pc_ld_hi), .ld_lo(pc_ld_lo), .hi_val(pc_hi_val), .lo_val(pc_lo_val),
    .pull_v(pull_valid), .irq_take(irq_take), .busy(busy), .step(step)
  );

  // pre-increment reads, write-then-decrement writes, both inside the page
  always_comb begin
    if (mem_rd)      mem_addr = {page_w, sp_plus_w};
    else if (mem_wr) mem_addr = {page_w, sp_out};
    else             mem_addr = '0;
  end

  assign pull_data = pull_valid ? mem_rdata : '0;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));  // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr && !pc_ld_hi && !pc_ld_lo);  // R12

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> sp_out == $past(sp_out) - 1'b1);  // R2

  AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> sp_out == $past(sp_out) + 1'b1);  // R3

  AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr[DW-1:0] == sp_out);  // R11

  AST_PAGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_addr[AW-1:DW] == page_w);  // R9

  AST_MASK_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> mask_w);  // R8

  AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> busy && step == IRQ_FIRST);  // R13

endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        fetch_start, irq_pend, cmd_valid;
  logic [1:0]  cmd_op;
  logic [7:0]  push_data, status_in, mem_rdata, mem_wdata;
  logic [15:0] pc_in, call_target, mem_addr;
  logic        mem_rd, mem_wr, pc_ld_hi, pc_ld_lo, pull_valid, irq_take, busy;
  logic [7:0]  pc_hi_val, pc_lo_val, pull_data, sp_out;
  logic [2:0]  step;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] ram [0:255];
  logic [1:0] t_op;
  logic [7:0] t_d, t_sp, t_pull, sp_prev;

  localparam logic [7:0] PG = 8'h02;

  // {op, data, sp after, expected pulled byte}
  localparam logic [25:0] TBL [8] = '{
    {2'd0, 8'h11, 8'hFE, 8'h00},
    {2'd0, 8'h22, 8'hFD, 8'h00},
    {2'd0, 8'h33, 8'hFC, 8'h00},
    {2'd1, 8'h00, 8'hFD, 8'h33},
    {2'd0, 8'h44, 8'hFC, 8'h00},
    {2'd1, 8'h00, 8'hFD, 8'h44},
    {2'd1, 8'h00, 8'hFE, 8'h22},
    {2'd1, 8'h00, 8'hFF, 8'h11}
  };

  always #10 clk = ~clk;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_start(fetch_start),
    .irq_pend(irq_pend), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .pc_in(pc_in), .status_in(status_in),
    .call_target(call_target), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_ld_hi(pc_ld_hi), .pc_ld_lo(pc_ld_lo), .pc_hi_val(pc_hi_val),
    .pc_lo_val(pc_lo_val), .pull_valid(pull_valid), .pull_data(pull_data),
    .irq_take(irq_take), .busy(busy), .step(step), .sp_out(sp_out)
  );

  assign mem_rdata = ram[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d,
                       input logic [15:0] pc, input logic [15:0] tgt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; push_data = d; pc_in = pc; call_target = tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    check(req, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 8'h00;
    fetch_start = 1'b0; irq_pend = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0;
    push_data = 8'h00; pc_in = 16'h0000; status_in = 8'h00; call_target = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sp", {24'd0, sp_out}, 32'hFF);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 step", {29'd0, step}, 0);
    check("R1 strobes", {28'd0, mem_rd, mem_wr, pc_ld_hi, pc_ld_lo}, 0);
    cfg_check("R1 page", 2'd0, 8'h01);
    cfg_check("R1 vec hi", 2'd1, 8'h00);
    cfg_check("R1 vec lo", 2'd2, 8'h00);
    cfg_check("R1 mask", 2'd3, 8'h01);

    // R9 page write and readback
    cfg_write(2'd0, PG);
    cfg_check("R9 page", 2'd0, PG);

    // R2 R3 push/pull table
    sp_prev = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      {t_op, t_d, t_sp, t_pull} = TBL[i];
      issue(t_op, t_d, 16'h0, 16'h0);
      check("R13 cmd step", {29'd0, step}, 2);
      if (t_op == 2'd0) begin
        check("R2 push wr", {30'd0, mem_wr, mem_rd}, 2);
        check("R2 push addr", {16'd0, mem_addr}, {16'd0, PG, sp_prev});
        check("R2 push data", {24'd0, mem_wdata}, {24'd0, t_d});
      end else begin
        check("R3 pull rd", {30'd0, mem_rd, pull_valid}, 3);
        check("R3 pull addr", {16'd0, mem_addr}, {16'd0, PG, sp_prev + 8'd1});
        check("R3 pull data", {24'd0, pull_data}, {24'd0, t_pull});
      end
      @(negedge clk);
      check("R2 R3 idle", {31'd0, busy}, 0);
      check("R2 R3 sp", {24'd0, sp_out}, {24'd0, t_sp});
      sp_prev = t_sp;
    end

    // R4 call
    issue(2'd2, 8'h00, 16'h1234, 16'h0456);
    check("R4 s2", {14'd0, mem_wr, step, mem_addr, mem_wdata} >> 0,
          {14'd0, 1'b1, 3'd2, PG, 8'hFF, 8'h12});
    @(negedge clk);
    check("R4 s3", {15'd0, mem_wr, mem_addr, mem_wdata} >> 0, {15'd0, 1'b1, PG, 8'hFE, 8'h34});
    @(negedge clk);
    check("R4 s4 loads", {11'd0, mem_wr, pc_ld_hi, pc_ld_lo, step, pc_hi_val, pc_lo_val},
          {11'd0, 1'b0, 1'b1, 1'b1, 3'd4, 8'h04, 8'h56});
    @(negedge clk);
    check("R4 sp", {23'd0, busy, sp_out}, {23'd0, 1'b0, 8'hFD});
    check("R4 ret lo at SP+1", {24'd0, ram[8'hFE]}, 32'h34);
    check("R4 ret hi at SP+2", {24'd0, ram[8'hFF]}, 32'h12);

    // R5 return
    issue(2'd3, 8'h00, 16'h0, 16'h0);
    check("R5 s2", {6'd0, mem_rd, pc_ld_lo, pc_ld_hi, mem_addr, pc_lo_val},
          {6'd0, 1'b1, 1'b1, 1'b0, PG, 8'hFE, 8'h34});
    @(negedge clk);
    check("R5 s3", {6'd0, mem_rd, pc_ld_hi, pc_ld_lo, mem_addr, pc_hi_val},
          {6'd0, 1'b1, 1'b1, 1'b0, PG, 8'hFF, 8'h12});
    @(negedge clk);
    check("R5 sp", {23'd0, busy, sp_out}, {23'd0, 1'b0, 8'hFF});

    // R11 wrap both ways
    issue(2'd1, 8'h00, 16'h0, 16'h0);
    check("R11 pull wrap addr", {16'd0, mem_addr}, {16'd0, PG, 8'h00});
    @(negedge clk);
    check("R11 sp 00", {24'd0, sp_out}, 32'h00);
    issue(2'd0, 8'h5A, 16'h0, 16'h0);
    check("R11 push at 00", {16'd0, mem_addr}, {16'd0, PG, 8'h00});
    @(negedge clk);
    check("R11 sp FF", {24'd0, sp_out}, 32'hFF);
    check("R11 ram00", {24'd0, ram[0]}, 32'h5A);

    // R10 command while busy dropped
    issue(2'd2, 8'h00, 16'h2001, 16'h0300);
    cmd_valid = 1'b1; cmd_op = 2'd0; push_data = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 busy drop sp", {23'd0, busy, sp_out}, {23'd0, 1'b0, 8'hFD});
    issue(2'd3, 8'h00, 16'h0, 16'h0);
    check("R10 ret lo", {24'd0, pc_lo_val}, 32'h01);
    @(negedge clk);
    check("R10 ret hi", {24'd0, pc_hi_val}, 32'h20);
    @(negedge clk);
    check("R10 sp back", {24'd0, sp_out}, 32'hFF);

    // R6 masked and non-fetch requests ignored
    cfg_write(2'd1, 8'h80);
    cfg_write(2'd2, 8'h10);
    fetch_start = 1'b1; irq_pend = 1'b1;
    #2;
    check("R6 masked no take", {31'd0, irq_take}, 0);
    @(negedge clk);
    fetch_start = 1'b0; irq_pend = 1'b0;
    check("R6 masked idle", {31'd0, busy}, 0);
    cfg_write(2'd3, 8'h00);
    cfg_check("R8 mask cleared", 2'd3, 8'h00);
    irq_pend = 1'b1;
    #2;
    check("R6 no fetch no take", {31'd0, irq_take}, 0);
    @(negedge clk);
    check("R6 no fetch idle", {31'd0, busy}, 0);

    // R7 entry, R10 same-cycle command dropped
    fetch_start = 1'b1; pc_in = 16'hABCD; status_in = 8'h5C;
    cmd_valid = 1'b1; cmd_op = 2'd0; push_data = 8'h77;
    #2;
    check("R6 take", {31'd0, irq_take}, 1);
    @(negedge clk);
    fetch_start = 1'b0; irq_pend = 1'b0; cmd_valid = 1'b0;
    check("R7 s0", {12'd0, mem_wr, step, mem_addr, mem_wdata} >> 0,
          {12'd0, 1'b1, 3'd0, PG, 8'hFF, 8'hAB});
    @(negedge clk);
    check("R7 s1", {15'd0, mem_wr, mem_addr, mem_wdata}, {15'd0, 1'b1, PG, 8'hFE, 8'hCD});
    @(negedge clk);
    check("R7 s2", {15'd0, mem_wr, mem_addr, mem_wdata}, {15'd0, 1'b1, PG, 8'hFD, 8'h5C});
    @(negedge clk);
    check("R7 s3", {21'd0, mem_wr, pc_ld_hi, pc_ld_lo, pc_hi_val}, {21'd0, 1'b0, 1'b1, 1'b0, 8'h80});
    @(negedge clk);
    check("R7 s4", {18'd0, pc_ld_hi, pc_ld_lo, step, pc_lo_val}, {18'd0, 1'b0, 1'b1, 3'd4, 8'h10});
    @(negedge clk);
    check("R7 R10 sp", {23'd0, busy, sp_out}, {23'd0, 1'b0, 8'hFC});
    cfg_check("R8 mask set", 2'd3, 8'h01);

    // R8 mask blocks a new request
    fetch_start = 1'b1; irq_pend = 1'b1;
    #2;
    check("R8 blocked", {31'd0, irq_take}, 0);
    @(negedge clk);
    fetch_start = 1'b0; irq_pend = 1'b0;
    check("R8 still idle", {31'd0, busy}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule